// File: doc/BRIEF.md
# Switch State Interrupt Peripheral

This block holds one 32-bit switch state for a host processor and signals every change of that state on a single level-sensitive interrupt line. The host reaches it through a plain word-addressed bus with an address, separate read and write strobes, write data and registered read data, decoded over a 4 KiB window. New states arrive on an input port. When the block is built as an output switch, a host write to the state register is handed to an external handler through a request/acknowledge pair, and the state the handler returns is taken in only when it differs from the current one.

The host enables the interrupt with one bit and acknowledges a change by reading the status register. That read clears the pending change only while the interrupt is enabled. Toggling the enable bit while a change is pending moves the interrupt line with it at once. A fixed name length and a flags word that reports the build mode can also be read. A write of the name pointer is accepted and has no effect. Any access the block does not support sets a sticky error output and reads back as zero.

Top module: `swchg_irq_top`

## Requirements
- R1: After reset the state is 0, no change is pending, the enable bit is 0, and the outputs `irq`, `err`, `hnd_req` and `bus_rdata` are all 0.
- R2: A read of byte offset 0x000 returns the NAME_LEN parameter. A read of offset 0x008 returns a word whose bit 0 is 1 in output mode (OUT_MODE=1) and 0 in input mode, with every other bit 0.
- R3: A cycle with `sw_in_valid` high stores `sw_in_state` as the state and sets the pending flag, even if the value is unchanged. From the next cycle the state reads back at offset 0x00C and `irq` is high if the enable bit is 1.
- R4: A read of offset 0x010 returns 1 when a change is pending and the enable bit is 1, and that read clears the pending flag and drops `irq`. In every other case the read returns 0 and changes nothing.
- R5: A write to offset 0x014 stores only bit 0 of the data as the enable bit. While a change is pending, `irq` equals the new enable value from the next cycle on.
- R6: In output mode a write to offset 0x00C while no handshake is open raises `hnd_req` for exactly one cycle, the cycle after the write, with `hnd_value` equal to the written data. Further writes to 0x00C are ignored until `hnd_ack` arrives.
- R7: On `hnd_ack` during an open handshake, `hnd_result` becomes the state, with the pending flag and interrupt as in R3, only if it differs from the current state. Otherwise nothing changes.
- R8: The following are illegal: a read of 0x004 or 0x014, a write to 0x000, 0x008 or 0x010, a write to 0x00C in input mode, and any access to another offset, including offsets that are not word aligned. An illegal access sets `err`, which stays set until reset. It changes no state, and a read returns 0.
- R9: A write to offset 0x004 is accepted and has no effect. It does not set `err` and does not change the state or the interrupt.
- R10: When an input-port update and a clearing status read fall in the same cycle, the read returns 1, but the pending flag and `irq` stay set.
- R11: Read data is registered. A read strobe in one cycle presents its data on `bus_rdata` from the next cycle until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sw_in_valid | input | 1 | New switch state present |
| sw_in_state | input | DATA_W | New switch state |
| hnd_req | output | 1 | One-cycle request to the external handler |
| hnd_value | output | DATA_W | Value written by the host, held for the handler |
| hnd_ack | input | 1 | Handler done |
| hnd_result | input | DATA_W | State returned by the handler |
| irq | output | 1 | Level interrupt |
| err | output | 1 | Sticky illegal-access flag |

## Verification
Every result of a strobe applied in one cycle is due in the next cycle: read data, `irq` after an input update, an enable write, a clearing read or an acknowledge, `hnd_req` after a state write, and `err` after an illegal access. The bench drives each strobe for one clock cycle, starting on a falling edge. It samples on the following falling edge, which is the first point where the single register stage has updated. It checks again a cycle later for the one-cycle request pulse and for the ignored write while a handshake is open. A sweep over every word offset of the window on an input-mode instance checks the read data due in that cycle against values the bench computes from the offset.

// File: rtl/swchg_pkg.sv
`timescale 1ns/1ps
package swchg_pkg;
  // Byte offsets inside the decoded window; software depends on these.
  localparam int OFF_NAMELEN = 'h000;
  localparam int OFF_NAMEPTR = 'h004;
  localparam int OFF_FLAGS   = 'h008;
  localparam int OFF_STATE   = 'h00C;
  localparam int OFF_STATUS  = 'h010;
  localparam int OFF_ENABLE  = 'h014;

  // One decoded bus access, at most one read kind and one write kind set.
  typedef struct packed {
    logic rd_namelen;
    logic rd_flags;
    logic rd_state;
    logic rd_status;
    logic wr_nameptr;
    logic wr_state;
    logic wr_enable;
    logic bad;
  } acc_t;
endpackage

// File: rtl/swchg_decode.sv
`timescale 1ns/1ps
module swchg_decode
  import swchg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter bit OUT_MODE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output acc_t              acc
);
  logic rd_bad, wr_bad;

  always_comb begin
    acc    = '0;
    rd_bad = 1'b0;
    wr_bad = 1'b0;
    if (rd) begin
      if      (addr == ADDR_W'(OFF_NAMELEN)) acc.rd_namelen = 1'b1;
      else if (addr == ADDR_W'(OFF_FLAGS))   acc.rd_flags   = 1'b1;
      else if (addr == ADDR_W'(OFF_STATE))   acc.rd_state   = 1'b1;
      else if (addr == ADDR_W'(OFF_STATUS))  acc.rd_status  = 1'b1;
      else                                   rd_bad         = 1'b1;
    end
    if (wr) begin
      if      (addr == ADDR_W'(OFF_NAMEPTR)) acc.wr_nameptr = 1'b1;
      else if (addr == ADDR_W'(OFF_ENABLE))  acc.wr_enable  = 1'b1;
      else if (addr == ADDR_W'(OFF_STATE) && OUT_MODE) acc.wr_state = 1'b1;
      else                                   wr_bad         = 1'b1;
    end
    acc.bad = rd_bad | wr_bad;
  end
endmodule

// File: rtl/swchg_handshake.sv
`timescale 1ns/1ps
module swchg_handshake #(
  parameter int DATA_W   = 32,
  parameter bit OUT_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] result,
  output logic              req,
  output logic [DATA_W-1:0] value,
  output logic              apply,
  output logic [DATA_W-1:0] apply_state
);
  generate
    if (OUT_MODE) begin : g_out
      logic busy_q, req_q;
      logic [DATA_W-1:0] value_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          busy_q  <= 1'b0;
          req_q   <= 1'b0;
          value_q <= '0;
        end else begin
          req_q <= start && !busy_q;
          if (start && !busy_q) begin
            busy_q  <= 1'b1;
            value_q <= wdata;
          end else if (ack && busy_q) begin
            busy_q <= 1'b0;
          end
        end
      end

      assign req         = req_q;
      assign value       = value_q;
      assign apply       = ack && busy_q;
      assign apply_state = result;

      // R6: the request is a single-cycle pulse
      a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);
      // R6: a state write during an open handshake raises no request
      a_r6_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ack && start) |=> (!req_q && $stable(value_q)));
    end else begin : g_none
      assign req         = 1'b0;
      assign value       = '0;
      assign apply       = 1'b0;
      assign apply_state = '0;
    end
  endgenerate
endmodule

// File: rtl/swchg_core.sv
`timescale 1ns/1ps
module swchg_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_state,
  input  logic              hs_apply,
  input  logic [DATA_W-1:0] hs_state,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] state,
  output logic              pend,
  output logic              en,
  output logic              irq
);
  logic [DATA_W-1:0] state_q, new_state;
  logic pend_q, en_q, irq_q;
  logic take_hs, apply, clr, en_n, irq_n;

  // The input port outranks the handler when both land in one cycle.
  assign take_hs   = hs_apply && (hs_state != state_q);
  assign apply     = in_valid || take_hs;
  assign new_state = in_valid ? in_state : hs_state;
  assign clr       = stat_rd && pend_q && en_q;
  assign en_n      = en_wr ? en_val : en_q;

  always_comb begin
    irq_n = irq_q;
    if (en_wr && pend_q && (en_q != en_val)) irq_n = en_val;
    if (clr)   irq_n = 1'b0;
    if (apply) irq_n = en_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      en_q  <= en_n;
      irq_q <= irq_n;
      if (apply) begin
        state_q <= new_state;
        pend_q  <= 1'b1;
      end else if (clr) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign state = state_q;
  assign pend  = pend_q;
  assign en    = en_q;
  assign irq   = irq_q;

  // R5: the line always mirrors a pending change gated by the enable
  a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q && en_q));
  // R3: an input update lands in the state and marks it pending
  a_r3_input_taken: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (state_q == $past(in_state)) && pend_q);
  // R7: an unchanged handler result leaves the state alone
  a_r7_same_ignored: assert property (@(posedge clk) disable iff (rst)
    (hs_apply && !in_valid && hs_state == state_q) |=> $stable(state_q));
  // R10: an update beats a clearing read in the same cycle
  a_r10_update_wins: assert property (@(posedge clk) disable iff (rst)
    (in_valid && stat_rd) |=> pend_q);
endmodule

// File: rtl/swchg_irq_top.sv
`timescale 1ns/1ps
module swchg_irq_top
  import swchg_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int WINDOW_BYTES = 4096,
  parameter int NAME_LEN     = 8,
  parameter bit OUT_MODE     = 1'b1,
  localparam int ADDR_W      = $clog2(WINDOW_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sw_in_valid,
  input  logic [DATA_W-1:0] sw_in_state,
  output logic              hnd_req,
  output logic [DATA_W-1:0] hnd_value,
  input  logic              hnd_ack,
  input  logic [DATA_W-1:0] hnd_result,
  output logic              irq,
  output logic              err
);
  acc_t acc;
  logic hs_apply;
  logic [DATA_W-1:0] hs_state, state;
  logic pend, en;
  logic [DATA_W-1:0] rdata_q;
  logic err_q;

  swchg_decode #(.ADDR_W(ADDR_W), .OUT_MODE(OUT_MODE)) u_decode (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .acc  (acc)
  );

  swchg_handshake #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE)) u_hs (
    .clk         (clk),
    .rst         (rst),
    .start       (acc.wr_state),
    .wdata       (bus_wdata),
    .ack         (hnd_ack),
    .result      (hnd_result),
    .req         (hnd_req),
    .value       (hnd_value),
    .apply       (hs_apply),
    .apply_state (hs_state)
  );

  swchg_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .in_valid (sw_in_valid),
    .in_state (sw_in_state),
    .hs_apply (hs_apply),
    .hs_state (hs_state),
    .en_wr    (acc.wr_enable),
    .en_val   (bus_wdata[0]),
    .stat_rd  (acc.rd_status),
    .state    (state),
    .pend     (pend),
    .en       (en),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (bus_rd) begin
        if      (acc.rd_namelen) rdata_q <= DATA_W'(NAME_LEN);
        else if (acc.rd_flags)   rdata_q <= DATA_W'(OUT_MODE);
        else if (acc.rd_state)   rdata_q <= state;
        else if (acc.rd_status)  rdata_q <= DATA_W'(pend && en);
        else                     rdata_q <= '0;
      end
      if (acc.bad) err_q <= 1'b1;
    end
  end

  assign bus_rdata = rdata_q;
  assign err       = err_q;

  // R8: the error flag never falls before reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R9: a name-pointer write alone never raises the error flag
  a_r9_nameptr_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc.wr_nameptr && !bus_rd && !err_q) |=> !err_q);
  // R8: an illegal read returns zero
  a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !(acc.rd_namelen || acc.rd_flags || acc.rd_state || acc.rd_status))
      |=> (rdata_q == '0));
endmodule

// File: tb/swchg_irq_top_tb.sv
`timescale 1ns/1ps
module swchg_irq_top_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic a_rd = 0, a_wr = 0, b_rd = 0, b_wr = 0;
  logic a_inv = 0, b_inv = 0;
  logic [31:0] a_ins = '0, b_ins = '0;
  logic a_ack = 0, b_ack = 0;
  logic [31:0] a_res = '0, b_res = '0;
  logic [31:0] a_rdata, b_rdata, a_val, b_val;
  logic a_req, b_req, a_irq, b_irq, a_err, b_err;
  int total = 0, bad = 0;

  swchg_irq_top #(.NAME_LEN(11), .OUT_MODE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(a_rd), .bus_wr(a_wr),
    .bus_wdata(wdata), .bus_rdata(a_rdata), .sw_in_valid(a_inv),
    .sw_in_state(a_ins), .hnd_req(a_req), .hnd_value(a_val), .hnd_ack(a_ack),
    .hnd_result(a_res), .irq(a_irq), .err(a_err));

  swchg_irq_top #(.NAME_LEN(5), .OUT_MODE(1'b0)) u_din (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(b_rd), .bus_wr(b_wr),
    .bus_wdata(wdata), .bus_rdata(b_rdata), .sw_in_valid(b_inv),
    .sw_in_state(b_ins), .hnd_req(b_req), .hnd_value(b_val), .hnd_ack(b_ack),
    .hnd_result(b_res), .irq(b_irq), .err(b_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input bit sel, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    if (sel) b_rd = 1; else a_rd = 1;
    @(negedge clk);
    a_rd = 0; b_rd = 0;
    d = sel ? b_rdata : a_rdata;
  endtask

  task automatic wr(input bit sel, input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    addr = a; wdata = v;
    if (sel) b_wr = 1; else a_wr = 1;
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic push(input bit sel, input logic [31:0] v);
    @(negedge clk);
    if (sel) begin b_inv = 1; b_ins = v; end else begin a_inv = 1; a_ins = v; end
    @(negedge clk);
    a_inv = 0; b_inv = 0;
  endtask

  task automatic ack_a(input logic [31:0] r);
    @(negedge clk);
    a_ack = 1; a_res = r;
    @(negedge clk);
    a_ack = 0;
  endtask

  function automatic logic [31:0] exp_in_mode(input int off, input logic [31:0] st);
    case (off)
      'h000:   return 32'd5;
      'h008:   return 32'd0;
      'h00C:   return st;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    #500us;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", a_rdata, 0);
    chk("R1 irq", {31'd0, a_irq}, 0);
    chk("R1 err", {31'd0, a_err}, 0);
    chk("R1 req", {31'd0, a_req}, 0);
    rd(0, 12'h00C, d); chk("R1 state", d, 0);
    // R2 identity words, R11 registered read
    rd(0, 12'h000, d); chk("R2 R11 namelen out", d, 11);
    rd(0, 12'h008, d); chk("R2 flags out", d, 1);
    rd(1, 12'h000, d); chk("R2 namelen in", d, 5);
    rd(1, 12'h008, d); chk("R2 flags in", d, 0);
    // R3 update with enable off
    push(0, 32'h5A);
    chk("R3 irq masked", {31'd0, a_irq}, 0);
    rd(0, 12'h00C, d); chk("R3 state", d, 32'h5A);
    rd(0, 12'h010, d); chk("R4 status disabled", d, 0);
    // R5 enabling with a change pending
    wr(0, 12'h014, 32'hFFFF_FFFF);
    chk("R5 irq follows enable", {31'd0, a_irq}, 1);
    rd(0, 12'h010, d); chk("R4 status hit", d, 1);
    chk("R4 irq cleared", {31'd0, a_irq}, 0);
    rd(0, 12'h010, d); chk("R4 status empty", d, 0);
    // R3 with enable on, R5 toggles
    push(0, 32'hA5);
    chk("R3 irq raised", {31'd0, a_irq}, 1);
    wr(0, 12'h014, 32'h0); chk("R5 irq off", {31'd0, a_irq}, 0);
    wr(0, 12'h014, 32'h2); chk("R5 bit1 ignored", {31'd0, a_irq}, 0);
    wr(0, 12'h014, 32'h3); chk("R5 irq back", {31'd0, a_irq}, 1);
    // R10 update and clearing read together
    @(negedge clk);
    addr = 12'h010; a_rd = 1; a_inv = 1; a_ins = 32'h77;
    @(negedge clk);
    a_rd = 0; a_inv = 0;
    chk("R10 read value", a_rdata, 1);
    chk("R10 irq kept", {31'd0, a_irq}, 1);
    rd(0, 12'h00C, d); chk("R10 state", d, 32'h77);
    rd(0, 12'h010, d); chk("R10 still pending", d, 1);
    chk("R4 irq cleared again", {31'd0, a_irq}, 0);
    // R6 handshake
    wr(0, 12'h00C, 32'h123);
    chk("R6 req pulse", {31'd0, a_req}, 1);
    chk("R6 value", a_val, 32'h123);
    @(negedge clk);
    chk("R6 req single", {31'd0, a_req}, 0);
    wr(0, 12'h00C, 32'h456);
    chk("R6 busy no req", {31'd0, a_req}, 0);
    @(negedge clk);
    chk("R6 busy no req later", {31'd0, a_req}, 0);
    chk("R6 value held", a_val, 32'h123);
    rd(0, 12'h00C, d); chk("R6 state untouched", d, 32'h77);
    // R7 result applied when different
    ack_a(32'h123);
    chk("R7 irq on change", {31'd0, a_irq}, 1);
    rd(0, 12'h00C, d); chk("R7 state", d, 32'h123);
    rd(0, 12'h010, d); chk("R7 status", d, 1);
    wr(0, 12'h00C, 32'h999);
    chk("R6 req after ack", {31'd0, a_req}, 1);
    ack_a(32'h123);
    chk("R7 same no irq", {31'd0, a_irq}, 0);
    rd(0, 12'h010, d); chk("R7 nothing pending", d, 0);
    rd(0, 12'h00C, d); chk("R7 state same", d, 32'h123);
    // R9 name pointer write
    wr(0, 12'h004, 32'hDEAD_BEEF);
    chk("R9 no err", {31'd0, a_err}, 0);
    chk("R9 irq unchanged", {31'd0, a_irq}, 0);
    rd(0, 12'h00C, d); chk("R9 state", d, 32'h123);
    // R8 illegal on the output instance
    rd(0, 12'h014, d); chk("R8 read enable zero", d, 0);
    chk("R8 err set", {31'd0, a_err}, 1);
    wr(0, 12'h010, 32'h1);
    rd(0, 12'h00C, d); chk("R8 state kept", d, 32'h123);
    chk("R8 err stays", {31'd0, a_err}, 1);
    // R8 input-mode state write
    push(1, 32'h33);
    chk("R3 input inst err clear", {31'd0, b_err}, 0);
    wr(1, 12'h00C, 32'h44);
    chk("R8 input write err", {31'd0, b_err}, 1);
    chk("R8 input no req", {31'd0, b_req}, 0);
    rd(1, 12'h00C, d); chk("R8 input state kept", d, 32'h33);
    // R8 R2 sweep of every word offset on the input instance
    for (int i = 0; i < 1024; i++) begin
      rd(1, 12'(i * 4), d);
      chk($sformatf("R8 sweep off %h", i * 4), d, exp_in_mode(i * 4, 32'h33));
    end
    rd(1, 12'h00D, d); chk("R8 unaligned", d, 0);
    rd(1, 12'h001, d); chk("R8 unaligned low", d, 0);
    chk("R8 err final", {31'd0, b_err}, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule